// File: doc/BRIEF.md
# Paired Translation Buffer with Selective Invalidation

This block holds two small fully associative translation caches for 4 KB pages, one serving instruction fetch and one serving data access. Each side turns a 32-bit virtual address and an 8-bit address space tag into a 32-bit physical address in the same cycle. Translations are installed by refill writes from an external walker. Each refill names the side it is meant for.

Maintenance commands arrive as a kind code, a two-bit target mask and a 32-bit operand word. The four kinds are:
- remove everything;
- remove one page within one address space;
- remove one whole address space;
- remove one page in every address space.

The target mask steers the command to the instruction side, the data side or both sides. Entries marked global translate under any address space tag and are immune to removal by address space.

Top module: `tlb_pair`

## Requirements
- R1: After reset every entry on both sides is invalid, so every lookup misses and its physical address output is zero.
- R2: A lookup hits when a valid entry has a page equal to va[31:12] and either its tag equals the lookup tag or the entry is global. On a hit the physical address is {page frame, va[11:0]}, with no clock edge in between. On a miss it is zero. If several entries match, the lowest index wins.
- R3: A refill writes only the side chosen by fill_side_i (0 = instruction, 1 = data). It goes into the lowest-index invalid entry and can be looked up from the cycle after the write.
- R4: When a side is full and the refill matches no entry, a round-robin victim is replaced. The victim pointer is 0 after reset, advances by one on each such replacement and wraps after the last entry.
- R5: A refill whose page equals that of a valid entry, where the tags are equal or either of the two is global, overwrites that entry instead of adding another.
- R6: Kind 0 removes every valid entry on the targeted sides.
- R7: Kind 1 removes entries whose page equals operand bits 31:12 and whose tag equals operand bits 7:0. A global entry with that page is also removed.
- R8: Kind 2 removes non-global entries whose tag equals operand bits 7:0, at any page. Global entries stay.
- R9: Kind 3 removes every entry whose page equals operand bits 31:12, whatever its tag or global flag.
- R10: mnt_tgt_i bit 0 selects the instruction side and bit 1 the data side. A mask of zero, or mnt_en_i low, changes nothing.
- R11: A maintenance command takes effect in one cycle. A lookup in that same cycle already sees the state after removal.
- R12: Operand bits 11:0 play no part in page matching, and operand bits 11:8 play no part in tag matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| i_va_i | input | 32 | Instruction-side lookup virtual address |
| i_asid_i | input | 8 | Instruction-side lookup address space tag |
| i_hit_o | output | 1 | Instruction-side hit |
| i_pa_o | output | 32 | Instruction-side physical address |
| d_va_i | input | 32 | Data-side lookup virtual address |
| d_asid_i | input | 8 | Data-side lookup address space tag |
| d_hit_o | output | 1 | Data-side hit |
| d_pa_o | output | 32 | Data-side physical address |
| fill_en_i | input | 1 | Refill write strobe |
| fill_side_i | input | 1 | Refill side, 0 instruction, 1 data |
| fill_vpn_i | input | 20 | Refill virtual page |
| fill_asid_i | input | 8 | Refill address space tag |
| fill_glob_i | input | 1 | Refill global flag |
| fill_ppn_i | input | 20 | Refill physical page frame |
| mnt_en_i | input | 1 | Maintenance command strobe |
| mnt_kind_i | input | 2 | Maintenance kind, 0 all, 1 page+tag, 2 tag, 3 page |
| mnt_tgt_i | input | 2 | Target mask, bit 0 instruction, bit 1 data |
| mnt_data_i | input | 32 | Maintenance operand word |

## Verification
Lookup results are combinational. The bench drives a lookup on the falling edge and compares hit and address 1 ns later, within that same low phase. Refills and maintenance commands are driven on a falling edge and commit on the next rising edge. Their effect is first compared on the falling edge after that, through a full sweep over 40 pages and 4 tags on both sides, checked against an arithmetic model. The same-cycle rule is checked by sampling a lookup while its removal command is still being driven, before the committing edge.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned VA_W     = 32;
  localparam int unsigned PA_W     = 32;
  localparam int unsigned PG_OFF_W = 12;
  localparam int unsigned ASID_W   = 8;
  localparam int unsigned VPN_W    = VA_W - PG_OFF_W;
  localparam int unsigned PPN_W    = PA_W - PG_OFF_W;

  typedef enum logic [1:0] {
    INV_ALL     = 2'd0,
    INV_VA_ASID = 2'd1,
    INV_ASID    = 2'd2,
    INV_VA      = 2'd3
  } inv_kind_e;

  typedef struct packed {
    logic               en;
    inv_kind_e          kind;
    logic [VPN_W-1:0]   vpn;
    logic [ASID_W-1:0]  asid;
  } inv_cmd_t;

  typedef struct packed {
    logic               en;
    logic [VPN_W-1:0]   vpn;
    logic [ASID_W-1:0]  asid;
    logic               glob;
    logic [PPN_W-1:0]   ppn;
  } fill_t;
endpackage

// File: rtl/tlb_maint_dec.sv
module tlb_maint_dec
  import tlb_pkg::*;
#(
  parameter int unsigned NUM_SIDES = 2
) (
  input  logic                 mnt_en_i,
  input  logic [1:0]           mnt_kind_i,
  input  logic [NUM_SIDES-1:0] mnt_tgt_i,
  input  logic [VA_W-1:0]      mnt_data_i,
  output inv_cmd_t             cmd_o [NUM_SIDES]
);
  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    assign cmd_o[s] = '{en:   mnt_en_i && mnt_tgt_i[s],
                        kind: inv_kind_e'(mnt_kind_i),
                        vpn:  mnt_data_i[VA_W-1:PG_OFF_W],
                        asid: mnt_data_i[ASID_W-1:0]};
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int unsigned ENTRIES = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic [ENTRIES-1:0] free_i,
  input  logic [ENTRIES-1:0] match_i,
  output logic [ENTRIES-1:0] wr_vec_o
);
  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [IDX_W-1:0] rr_q, free_idx, match_idx;
  logic             use_rr;

  always_comb begin
    free_idx  = '0;
    match_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (free_i[i])  free_idx  = IDX_W'(i);
      if (match_i[i]) match_idx = IDX_W'(i);
    end
    wr_vec_o = '0;
    if (req_i) begin
      if (|match_i)     wr_vec_o[match_idx] = 1'b1;
      else if (|free_i) wr_vec_o[free_idx]  = 1'b1;
      else              wr_vec_o[rr_q]      = 1'b1;
    end
  end

  assign use_rr = req_i && !(|match_i) && !(|free_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rr_q <= '0;
    else if (use_rr) rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
  end

  // R3: one slot per refill
  a_r3_single_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |-> $onehot(wr_vec_o));
  a_r3_no_spurious_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> wr_vec_o == '0);
  // R5: a matching entry is reused, never a free one
  a_r5_reuse_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && |match_i) |-> (wr_vec_o & ~match_i) == '0);
  // R4: the pointer only moves when the side is full
  a_r4_rr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !use_rr |=> $stable(rr_q));
endmodule

// File: rtl/tlb_array.sv
module tlb_array
  import tlb_pkg::*;
#(
  parameter int unsigned ENTRIES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  inv_cmd_t          cmd_i,
  input  fill_t             fill_i,
  input  logic [VA_W-1:0]   lk_va_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  output logic              hit_o,
  output logic [PA_W-1:0]   pa_o
);
  logic [ENTRIES-1:0] vld_q, glb_q, kill_vec, vld_live, fill_match, lk_vec, wr_vec;
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [ASID_W-1:0]  asid_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q  [ENTRIES];
  logic [VPN_W-1:0]   lk_vpn;
  logic [PPN_W-1:0]   ppn_sel;

  assign lk_vpn = lk_va_i[VA_W-1:PG_OFF_W];

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      logic vpn_eq, asid_eq, k;
      vpn_eq  = vpn_q[i] == cmd_i.vpn;
      asid_eq = asid_q[i] == cmd_i.asid;
      unique case (cmd_i.kind)
        INV_ALL:     k = 1'b1;
        INV_VA_ASID: k = vpn_eq && (asid_eq || glb_q[i]);
        INV_ASID:    k = asid_eq && !glb_q[i];
        default:     k = vpn_eq;
      endcase
      kill_vec[i] = cmd_i.en && vld_q[i] && k;
    end
  end

  assign vld_live = vld_q & ~kill_vec;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      fill_match[i] = vld_live[i] && (vpn_q[i] == fill_i.vpn) &&
                      ((asid_q[i] == fill_i.asid) || glb_q[i] || fill_i.glob);
      lk_vec[i]     = vld_live[i] && (vpn_q[i] == lk_vpn) &&
                      ((asid_q[i] == lk_asid_i) || glb_q[i]);
    end
  end

  tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (fill_i.en),
    .free_i   (~vld_live),
    .match_i  (fill_match),
    .wr_vec_o (wr_vec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      glb_q <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        vpn_q[i]  <= '0;
        asid_q[i] <= '0;
        ppn_q[i]  <= '0;
      end
    end else begin
      vld_q <= vld_live | wr_vec;
      for (int i = 0; i < ENTRIES; i++) begin
        if (wr_vec[i]) begin
          vpn_q[i]  <= fill_i.vpn;
          asid_q[i] <= fill_i.asid;
          glb_q[i]  <= fill_i.glob;
          ppn_q[i]  <= fill_i.ppn;
        end
      end
    end
  end

  // lowest index wins
  always_comb begin
    ppn_sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (lk_vec[i]) ppn_sel = ppn_q[i];
  end

  assign hit_o = |lk_vec;
  assign pa_o  = hit_o ? {ppn_sel, lk_va_i[PG_OFF_W-1:0]} : '0;

  // R6: invalidate-all empties the side
  a_r6_all_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i.en && cmd_i.kind == INV_ALL && !fill_i.en) |=> vld_q == '0);
  // R8: address-space removal leaves global entries valid
  a_r8_global_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i.en && cmd_i.kind == INV_ASID) |=>
      (vld_q & $past(vld_q & glb_q)) == $past(vld_q & glb_q));
  // R2: page offset passes through on a hit
  a_r2_offset_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> pa_o[PG_OFF_W-1:0] == lk_va_i[PG_OFF_W-1:0]);
  // R2: a miss drives a zero address
  a_r2_miss_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> pa_o == '0);
  // R10: without command or refill the valid set holds
  a_r10_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmd_i.en && !fill_i.en) |=> vld_q == $past(vld_q));
endmodule

// File: rtl/tlb_pair.sv
module tlb_pair
  import tlb_pkg::*;
#(
  parameter int unsigned ENTRIES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [VA_W-1:0]   i_va_i,
  input  logic [ASID_W-1:0] i_asid_i,
  output logic              i_hit_o,
  output logic [PA_W-1:0]   i_pa_o,
  input  logic [VA_W-1:0]   d_va_i,
  input  logic [ASID_W-1:0] d_asid_i,
  output logic              d_hit_o,
  output logic [PA_W-1:0]   d_pa_o,
  input  logic              fill_en_i,
  input  logic              fill_side_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [ASID_W-1:0] fill_asid_i,
  input  logic              fill_glob_i,
  input  logic [PPN_W-1:0]  fill_ppn_i,
  input  logic              mnt_en_i,
  input  logic [1:0]        mnt_kind_i,
  input  logic [1:0]        mnt_tgt_i,
  input  logic [VA_W-1:0]   mnt_data_i
);
  localparam int unsigned SIDES = 2;

  inv_cmd_t          cmd   [SIDES];
  fill_t             fill  [SIDES];
  logic [VA_W-1:0]   lk_va [SIDES];
  logic [ASID_W-1:0] lk_as [SIDES];
  logic              hit   [SIDES];
  logic [PA_W-1:0]   pa    [SIDES];

  assign lk_va[0] = i_va_i;
  assign lk_as[0] = i_asid_i;
  assign lk_va[1] = d_va_i;
  assign lk_as[1] = d_asid_i;
  assign i_hit_o  = hit[0];
  assign i_pa_o   = pa[0];
  assign d_hit_o  = hit[1];
  assign d_pa_o   = pa[1];

  tlb_maint_dec #(.NUM_SIDES(SIDES)) u_dec (
    .mnt_en_i   (mnt_en_i),
    .mnt_kind_i (mnt_kind_i),
    .mnt_tgt_i  (mnt_tgt_i),
    .mnt_data_i (mnt_data_i),
    .cmd_o      (cmd)
  );

  for (genvar s = 0; s < SIDES; s++) begin : g_tlb
    assign fill[s] = '{en:   fill_en_i && (fill_side_i == 1'(s)),
                       vpn:  fill_vpn_i,
                       asid: fill_asid_i,
                       glob: fill_glob_i,
                       ppn:  fill_ppn_i};

    tlb_array #(.ENTRIES(ENTRIES)) u_arr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cmd_i     (cmd[s]),
      .fill_i    (fill[s]),
      .lk_va_i   (lk_va[s]),
      .lk_asid_i (lk_as[s]),
      .hit_o     (hit[s]),
      .pa_o      (pa[s])
    );
  end
endmodule

// File: tb/tlb_pair_bench.sv
module tlb_pair_bench;
  localparam int N = 16;
  localparam logic [19:0] VBASE = 20'hA0000;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [31:0] i_va_i = '0, d_va_i = '0, mnt_data_i = '0;
  logic [7:0]  i_asid_i = '0, d_asid_i = '0, fill_asid_i = '0;
  logic        i_hit_o, d_hit_o;
  logic [31:0] i_pa_o, d_pa_o;
  logic        fill_en_i = 1'b0, fill_side_i = 1'b0, fill_glob_i = 1'b0, mnt_en_i = 1'b0;
  logic [19:0] fill_vpn_i = '0, fill_ppn_i = '0;
  logic [1:0]  mnt_kind_i = '0, mnt_tgt_i = '0;

  int n_chk = 0, n_bad = 0;

  // reference state
  logic        m_vld  [2][N];
  logic [19:0] m_vpn  [2][N];
  logic [7:0]  m_asid [2][N];
  logic        m_glb  [2][N];
  logic [19:0] m_ppn  [2][N];
  int          m_rr   [2];

  always #5 clk_i = ~clk_i;

  tlb_pair u_tlb_pair (.*);

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    finish_run();
  end

  function automatic void model_fill(int s, logic [19:0] vpn, logic [7:0] asid, logic g, logic [19:0] ppn);
    int idx = -1;
    for (int i = N - 1; i >= 0; i--)
      if (m_vld[s][i] && m_vpn[s][i] == vpn && (m_asid[s][i] == asid || m_glb[s][i] || g)) idx = i;
    if (idx < 0)
      for (int i = N - 1; i >= 0; i--) if (!m_vld[s][i]) idx = i;
    if (idx < 0) begin
      idx = m_rr[s];
      m_rr[s] = (m_rr[s] + 1) % N;
    end
    m_vld[s][idx] = 1'b1; m_vpn[s][idx] = vpn; m_asid[s][idx] = asid;
    m_glb[s][idx] = g;    m_ppn[s][idx] = ppn;
  endfunction

  function automatic void model_inv(logic [1:0] kind, logic [1:0] tgt, logic [31:0] dat);
    for (int s = 0; s < 2; s++) begin
      if (!tgt[s]) continue;
      for (int i = 0; i < N; i++) begin
        logic pe, ae, k;
        pe = m_vpn[s][i] == dat[31:12];
        ae = m_asid[s][i] == dat[7:0];
        case (kind)
          2'd0:    k = 1'b1;
          2'd1:    k = pe && (ae || m_glb[s][i]);
          2'd2:    k = ae && !m_glb[s][i];
          default: k = pe;
        endcase
        if (k) m_vld[s][i] = 1'b0;
      end
    end
  endfunction

  function automatic logic [32:0] model_look(int s, logic [31:0] va, logic [7:0] asid);
    for (int i = 0; i < N; i++)
      if (m_vld[s][i] && m_vpn[s][i] == va[31:12] && (m_asid[s][i] == asid || m_glb[s][i]))
        return {1'b1, m_ppn[s][i], va[11:0]};
    return 33'd0;
  endfunction

  task automatic chk(string tag, int s, logic ah, logic [31:0] ap, logic [32:0] exp);
    n_chk++;
    if (ah !== exp[32] || ap !== exp[31:0]) begin
      n_bad++;
      $display("FAIL %s side%0d: actual hit=%0b pa=%h expected hit=%0b pa=%h",
               tag, s, ah, ap, exp[32], exp[31:0]);
    end
  endtask

  task automatic sweep(string tag);
    for (int v = 0; v < 40; v++)
      for (int a = 0; a < 4; a++) begin
        @(negedge clk_i);
        i_va_i = {VBASE + 20'(v), 12'((v * 37 + a * 91) & 12'hfff)};
        d_va_i = {VBASE + 20'(v), 12'((v * 53 + a * 17) & 12'hfff)};
        i_asid_i = 8'(a);
        d_asid_i = 8'(a);
        #1;
        chk(tag, 0, i_hit_o, i_pa_o, model_look(0, i_va_i, i_asid_i));
        chk(tag, 1, d_hit_o, d_pa_o, model_look(1, d_va_i, d_asid_i));
      end
  endtask

  task automatic do_fill(int s, int v, int asid, logic g, logic [19:0] ppn);
    @(negedge clk_i);
    fill_en_i = 1'b1; fill_side_i = 1'(s); fill_vpn_i = VBASE + 20'(v);
    fill_asid_i = 8'(asid); fill_glob_i = g; fill_ppn_i = ppn;
    model_fill(s, VBASE + 20'(v), 8'(asid), g, ppn);
    @(negedge clk_i);
    fill_en_i = 1'b0;
  endtask

  task automatic do_mnt(logic en, logic [1:0] kind, logic [1:0] tgt, logic [31:0] dat);
    @(negedge clk_i);
    mnt_en_i = en; mnt_kind_i = kind; mnt_tgt_i = tgt; mnt_data_i = dat;
    if (en) model_inv(kind, tgt, dat);
    @(negedge clk_i);
    mnt_en_i = 1'b0;
  endtask

  initial begin
    for (int s = 0; s < 2; s++) begin
      m_rr[s] = 0;
      for (int i = 0; i < N; i++) begin
        m_vld[s][i] = 0; m_vpn[s][i] = '0; m_asid[s][i] = '0; m_glb[s][i] = 0; m_ppn[s][i] = '0;
      end
    end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    sweep("R1 reset empty");

    // R3: side steering and lowest free slot; R2: global hits any tag
    for (int v = 0; v < 12; v++) do_fill(0, v, v % 4, v == 5, 20'h50000 + 20'(v));
    for (int v = 4; v < 16; v++) do_fill(1, v, v % 4, v == 9, 20'h60000 + 20'(v));
    sweep("R2 R3 fill and hit");

    // R5: overwrite on match, including through a global entry
    do_fill(0, 2, 2, 1'b0, 20'h77777);
    do_fill(0, 5, 1, 1'b0, 20'h70005);
    do_fill(1, 9, 3, 1'b1, 20'h70009);
    sweep("R5 refill overwrite");

    // R4: fill to capacity, then round-robin with wrap
    for (int v = 12; v < 38; v++) do_fill(0, v, v % 4, 1'b0, 20'h58000 + 20'(v));
    sweep("R4 round robin");

    // R11: same-cycle lookup sees removal
    @(negedge clk_i);
    i_va_i = {VBASE + 20'd37, 12'h123}; i_asid_i = 8'd1;
    mnt_en_i = 1'b1; mnt_kind_i = 2'd1; mnt_tgt_i = 2'b01;
    mnt_data_i = {VBASE + 20'd37, 12'h001};
    model_inv(2'd1, 2'b01, mnt_data_i);
    #1;
    chk("R11 same cycle", 0, i_hit_o, i_pa_o, 33'd0);
    @(negedge clk_i);
    mnt_en_i = 1'b0;
    sweep("R11 after removal");

    // R8 R12: tag removal with junk in bits 11:8, globals stay
    do_mnt(1'b1, 2'd2, 2'b10, 32'hFFFF_FF01);
    sweep("R8 R12 tag removal");

    // R9 R12: page removal in all tags, junk low bits
    do_mnt(1'b1, 2'd3, 2'b01, {VBASE + 20'd20, 12'hFFF});
    do_mnt(1'b1, 2'd3, 2'b11, {VBASE + 20'd9, 12'h5A5});
    sweep("R9 R12 page removal");

    // R7 R10: page plus tag on both sides
    do_mnt(1'b1, 2'd1, 2'b11, {VBASE + 20'd7, 12'h003});
    do_mnt(1'b1, 2'd1, 2'b11, {VBASE + 20'd14, 12'h002});
    sweep("R7 R10 page and tag");

    // R10: no target, or no strobe, changes nothing
    do_mnt(1'b1, 2'd0, 2'b00, 32'h0);
    do_mnt(1'b0, 2'd0, 2'b11, 32'h0);
    sweep("R10 no effect");

    // R6: clear instruction side only, then both
    do_mnt(1'b1, 2'd0, 2'b01, 32'hDEAD_BEEF);
    sweep("R6 clear instruction");
    do_fill(1, 30, 2, 1'b0, 20'h6AAAA);
    do_mnt(1'b1, 2'd0, 2'b11, 32'h0);
    sweep("R6 clear both");

    // R3 R4: refill after clear reuses lowest free slots
    do_fill(0, 1, 0, 1'b0, 20'h51111);
    do_fill(0, 3, 3, 1'b1, 20'h53333);
    do_fill(1, 2, 1, 1'b0, 20'h62222);
    sweep("R3 refill after clear");

    finish_run();
  end
endmodule